// File: doc/BRIEF.md
# I2C Slave Address Recognition Unit

This block watches a sampled I2C bus and decides whether an address frame concerns this device. It passes both bus lines through a synchronizer and finds START and STOP conditions. After a START it shifts in one 8-bit frame, most significant bit first, on rising SCL. The first seven bits are the address and the eighth bit is the read/write direction. The address is compared with a programmable own address, and an ignore mask can leave any address bit out of the comparison. The all-zero frame is treated as a general call. When the frame is accepted, the block pulls SDA low for the acknowledge clock.

Every completed frame is copied into a snoop register, whether or not this device was addressed. The block also reports a bus error when START or STOP breaks into an address byte or its acknowledge slot. The error aborts the transfer and leaves both lines released. Three sticky flags are available: own-address match, general call and bus error. Software clears each flag by writing 1 to it through a clear strobe.

Top module: `i2c_addr_recog`

## Requirements
- R1: After reset all flags are 0, the snoop register is 0x00, and both `sda_release_o` and `scl_release_o` are 1 (released).
- R2: After a START, the next eight rising SCL edges shift in a frame MSB first: bits 7..1 are the address and bit 0 is the read/write direction.
- R3: A frame other than 0x00 is accepted when `ack_en_i` is 1 and ((address XOR `own_addr_i`) AND NOT `addr_mask_i`) is 0. For example, own 0x55 with mask 0x05 accepts addresses 0x50, 0x51, 0x54 and 0x55 and rejects 0x57. Acceptance sets the match flag `adrs_o`.
- R4: When a frame is accepted, `sda_release_o` goes to 0 from the SCL fall after the eighth bit until the SCL fall after the ninth clock, so SDA reads 0 while SCL is high in the ninth clock.
- R5: The frame 0x00 is accepted as a general call only when both `gc_en_i` and `ack_en_i` are 1. Acceptance sets `gcs_o` and never sets `adrs_o`.
- R6: If the frame is 0x00 and either `gc_en_i` or `ack_en_i` is 0, the acknowledge slot is released (NACK) and no flag is set. An own-address match with `ack_en_i` at 0 is also NACKed with no flag set.
- R7: `snoop_o` takes every completed 8-bit frame, whether or not it was accepted.
- R8: After a rejected frame, the block ignores the bus until the next START. A later byte clocked without a START gets no acknowledge and leaves `snoop_o` unchanged.
- R9: A START or STOP after at least one address bit, or during the acknowledge slot, sets `buserr_o` and releases both lines. Frames that follow are ignored while `buserr_o` is 1.
- R10: While `clr_we_i` is 1, each set bit of `clr_bits_i` clears one flag: bit 0 clears `adrs_o`, bit 1 clears `gcs_o`, bit 2 clears `buserr_o`. Flags whose bits are 0 keep their value. Clearing `buserr_o` returns the block to idle, ready for the next START.
- R11: A repeated START after an address phase restarts address reception from bit 0 and does not raise `buserr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_release_o | output | 1 | 1 releases SDA, 0 pulls it low |
| scl_release_o | output | 1 | 1 releases SCL (never held) |
| own_addr_i | input | 7 | Own slave address |
| addr_mask_i | input | 7 | 1 = address bit left out of the comparison |
| gc_en_i | input | 1 | Enable general call recognition |
| ack_en_i | input | 1 | Enable acknowledge of accepted frames |
| clr_we_i | input | 1 | Flag clear strobe |
| clr_bits_i | input | 3 | Write-1-to-clear mask {buserr, gcs, adrs} |
| adrs_o | output | 1 | Own address matched flag |
| gcs_o | output | 1 | General call received flag |
| buserr_o | output | 1 | Bus error flag |
| snoop_o | output | 8 | Last frame seen on the bus |

## Verification
The hardest state to reach is a bus error. A START or STOP has to land inside an address byte or an acknowledge slot, and at the ports that means breaking the normal bit rhythm. The bench gets there with partial bytes: it clocks three or five address bits and then issues a STOP or START while SCL is high. It then shows that the error state is sticky by sending a frame that would otherwise match and seeing no acknowledge and no change to the snoop register. Finally it clears the error flag and checks that the same frame is acknowledged.

// File: rtl/i2c_ar_pkg.sv
package i2c_ar_pkg;
  localparam int AR_ADDR_W  = 7;
  localparam int AR_FRAME_W = AR_ADDR_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT_ACK,
    ST_ACK,
    ST_ACTIVE,
    ST_IGNORE,
    ST_ERR
  } ar_state_e;

  // Masked compare: bits set in mask are left out of the comparison.
  function automatic logic addr_hit(input logic [AR_ADDR_W-1:0] rx,
                                    input logic [AR_ADDR_W-1:0] own,
                                    input logic [AR_ADDR_W-1:0] mask);
    return ((rx ^ own) & ~mask) == '0;
  endfunction

  function automatic logic is_gen_call(input logic [AR_FRAME_W-1:0] frame);
    return frame == '0;
  endfunction
endpackage

// File: rtl/i2c_ar_sync.sv
module i2c_ar_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);
  logic [STAGES-1:0] scl_chain, sda_chain;
  logic scl_q, sda_q, scl_s;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= scl_i;
          sda_chain <= sda_i;
        end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= {scl_chain[STAGES-2:0], scl_i};
          sda_chain <= {sda_chain[STAGES-2:0], sda_i};
        end
    end
  endgenerate

  assign scl_s = scl_chain[STAGES-1];
  assign sda_s = sda_chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end

  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
endmodule

// File: rtl/i2c_ar_fsm.sv
module i2c_ar_fsm
  import i2c_ar_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sda_s,
  input  logic                  start_ev,
  input  logic                  stop_ev,
  input  logic                  scl_rise,
  input  logic                  scl_fall,
  input  logic [AR_ADDR_W-1:0]  own_addr,
  input  logic [AR_ADDR_W-1:0]  addr_mask,
  input  logic                  gc_en,
  input  logic                  ack_en,
  input  logic                  err_clr,
  output logic                  sda_low,
  output logic                  frame_done,
  output logic [AR_FRAME_W-1:0] next_frame,
  output logic                  set_adrs,
  output logic                  set_gcs,
  output logic                  set_err
);
  localparam int CNT_W = $clog2(AR_FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(AR_FRAME_W - 1);

  ar_state_e             state;
  logic [CNT_W-1:0]      bit_cnt;
  logic [AR_FRAME_W-2:0] shreg;
  logic                  acc_gc, acc_adr;
  logic                  line_ev, in_byte;

  assign line_ev    = start_ev | stop_ev;
  assign next_frame = {shreg, sda_s};
  assign in_byte    = (state == ST_ADDR && bit_cnt != '0) ||
                      state == ST_WAIT_ACK || state == ST_ACK;
  assign frame_done = state == ST_ADDR && scl_rise && !line_ev && bit_cnt == LAST_BIT;
  assign set_err    = in_byte && line_ev;
  assign set_adrs   = state == ST_WAIT_ACK && scl_fall && !line_ev && acc_adr;
  assign set_gcs    = state == ST_WAIT_ACK && scl_fall && !line_ev && acc_gc;
  assign sda_low    = state == ST_ACK;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      acc_gc  <= 1'b0;
      acc_adr <= 1'b0;
    end else if (set_err) begin
      state <= ST_ERR;
    end else begin
      unique case (state)
        ST_IDLE: if (start_ev) begin
          state   <= ST_ADDR;
          bit_cnt <= '0;
        end
        ST_ADDR: begin
          if (start_ev) bit_cnt <= '0;
          else if (stop_ev) state <= ST_IDLE;
          else if (scl_rise) begin
            shreg   <= next_frame[AR_FRAME_W-2:0];
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
              state   <= ST_WAIT_ACK;
              acc_gc  <= is_gen_call(next_frame) & gc_en & ack_en;
              acc_adr <= !is_gen_call(next_frame) & ack_en &
                         addr_hit(next_frame[AR_FRAME_W-1:1], own_addr, addr_mask);
            end
          end
        end
        ST_WAIT_ACK: if (scl_fall) state <= (acc_gc || acc_adr) ? ST_ACK : ST_IGNORE;
        ST_ACK:      if (scl_fall) state <= ST_ACTIVE;
        ST_ACTIVE, ST_IGNORE: begin
          if (start_ev) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
          end else if (stop_ev) state <= ST_IDLE;
        end
        ST_ERR:  if (err_clr) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
endmodule

// File: rtl/i2c_addr_recog.sv
module i2c_addr_recog
  import i2c_ar_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_release_o,
  output logic                  scl_release_o,
  input  logic [AR_ADDR_W-1:0]  own_addr_i,
  input  logic [AR_ADDR_W-1:0]  addr_mask_i,
  input  logic                  gc_en_i,
  input  logic                  ack_en_i,
  input  logic                  clr_we_i,
  input  logic [2:0]            clr_bits_i,
  output logic                  adrs_o,
  output logic                  gcs_o,
  output logic                  buserr_o,
  output logic [AR_FRAME_W-1:0] snoop_o
);
  logic sda_s, start_ev, stop_ev, scl_rise, scl_fall;
  logic sda_low, frame_done, set_adrs, set_gcs, set_err, err_clr;
  logic clr_adrs, clr_gcs, clr_err;
  logic [AR_FRAME_W-1:0] next_frame;

  i2c_ar_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  assign clr_adrs = clr_we_i & clr_bits_i[0];
  assign clr_gcs  = clr_we_i & clr_bits_i[1];
  assign clr_err  = clr_we_i & clr_bits_i[2];
  assign err_clr  = clr_err & buserr_o;

  i2c_ar_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .own_addr(own_addr_i), .addr_mask(addr_mask_i),
    .gc_en(gc_en_i), .ack_en(ack_en_i), .err_clr(err_clr),
    .sda_low(sda_low), .frame_done(frame_done), .next_frame(next_frame),
    .set_adrs(set_adrs), .set_gcs(set_gcs), .set_err(set_err)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      adrs_o   <= 1'b0;
      gcs_o    <= 1'b0;
      buserr_o <= 1'b0;
      snoop_o  <= '0;
    end else begin
      adrs_o   <= set_adrs | (adrs_o & ~clr_adrs);
      gcs_o    <= set_gcs | (gcs_o & ~clr_gcs);
      buserr_o <= set_err | (buserr_o & ~clr_err);
      if (frame_done) snoop_o <= next_frame;
    end

  assign sda_release_o = ~sda_low;
  assign scl_release_o = 1'b1;
endmodule

// File: rtl/i2c_ar_chk.sv
module i2c_ar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_ev,
  input logic       stop_ev,
  input logic       frame_done,
  input logic       sda_release_o,
  input logic       clr_we_i,
  input logic [2:0] clr_bits_i,
  input logic       adrs_o,
  input logic       gcs_o,
  input logic       buserr_o,
  input logic [7:0] snoop_o
);
  // R3
  adrs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adrs_o) |-> !sda_release_o);
  // R5
  gc_not_adrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(adrs_o) && $rose(gcs_o)));
  // R5
  gc_snoop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gcs_o) |-> snoop_o == 8'h00);
  // R7
  snoop_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(snoop_o) |-> $past(frame_done));
  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buserr_o) |-> $past(start_ev || stop_ev));
  // R9
  err_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buserr_o |-> sda_release_o);
  // R10
  err_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && clr_bits_i[2] && buserr_o) |=> !buserr_o);
endmodule

bind i2c_addr_recog i2c_ar_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .stop_ev(stop_ev),
  .frame_done(frame_done), .sda_release_o(sda_release_o),
  .clr_we_i(clr_we_i), .clr_bits_i(clr_bits_i), .adrs_o(adrs_o),
  .gcs_o(gcs_o), .buserr_o(buserr_o), .snoop_o(snoop_o)
);

// File: tb/test_i2c_addr_recog.sv
module test_i2c_addr_recog;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_tb = 1'b1;
  logic sda_rel, scl_rel;
  logic [6:0] own = 7'h55, mask = 7'h05;
  logic gc_en = 1'b0, ack_en = 1'b1, clr_we = 1'b0;
  logic [2:0] clr_bits = 3'b000;
  logic adrs, gcs, buserr;
  logic [7:0] snoop;
  logic sda_line;
  int checks = 0, failures = 0;
  bit ack;

  always #4 clk = ~clk;
  assign sda_line = sda_tb & sda_rel;

  i2c_addr_recog i_i2c_addr_recog (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_release_o(sda_rel), .scl_release_o(scl_rel),
    .own_addr_i(own), .addr_mask_i(mask), .gc_en_i(gc_en), .ack_en_i(ack_en),
    .clr_we_i(clr_we), .clr_bits_i(clr_bits),
    .adrs_o(adrs), .gcs_o(gcs), .buserr_o(buserr), .snoop_o(snoop)
  );

  typedef struct packed {
    logic [6:0] own;
    logic [6:0] mask;
    logic       gc;
    logic       ack;
    logic [7:0] frame;
    logic       e_ack;
    logic       e_adrs;
    logic       e_gcs;
  } vec_t;

  localparam vec_t VEC [11] = '{
    '{7'h55, 7'h05, 1'b0, 1'b1, 8'hA0, 1'b1, 1'b1, 1'b0},
    '{7'h55, 7'h05, 1'b0, 1'b1, 8'hA3, 1'b1, 1'b1, 1'b0},
    '{7'h55, 7'h05, 1'b0, 1'b1, 8'hA8, 1'b1, 1'b1, 1'b0},
    '{7'h55, 7'h05, 1'b0, 1'b1, 8'hAA, 1'b1, 1'b1, 1'b0},
    '{7'h55, 7'h05, 1'b0, 1'b1, 8'hAE, 1'b0, 1'b0, 1'b0},
    '{7'h55, 7'h05, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1},
    '{7'h55, 7'h05, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0},
    '{7'h55, 7'h05, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    '{7'h55, 7'h05, 1'b0, 1'b0, 8'hAA, 1'b0, 1'b0, 1'b0},
    '{7'h00, 7'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0},
    '{7'h12, 7'h7F, 1'b0, 1'b1, 8'h01, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    scl = 1'b0; wq(); sda_tb = 1'b1; wq(); scl = 1'b1; wq();
    sda_tb = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    scl = 1'b0; wq(); sda_tb = 1'b0; wq(); scl = 1'b1; wq();
    sda_tb = 1'b1; wq(2);
  endtask

  task automatic send_bit(input logic b);
    scl = 1'b0; sda_tb = b; wq(); scl = 1'b1; wq(2); scl = 1'b0; wq();
  endtask

  task automatic send_frame(input logic [7:0] f, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(f[i]);
    sda_tb = 1'b1; wq(); scl = 1'b1; wq();
    acked = (sda_line == 1'b0);
    wq(); scl = 1'b0; wq();
  endtask

  task automatic clear(input logic [2:0] b);
    @(negedge clk); clr_we = 1'b1; clr_bits = b;
    @(negedge clk); clr_we = 1'b0; clr_bits = 3'b000;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 adrs", {7'h0, adrs}, 8'h0);
    chk("R1 gcs", {7'h0, gcs}, 8'h0);
    chk("R1 buserr", {7'h0, buserr}, 8'h0);
    chk("R1 snoop", snoop, 8'h00);
    chk("R1 sda_rel", {7'h0, sda_rel}, 8'h1);
    chk("R1 scl_rel", {7'h0, scl_rel}, 8'h1);
    rst_n = 1'b1;
    wq(2);

    // R2 R3 R4 R5 R6 R7: vector table
    foreach (VEC[k]) begin
      own = VEC[k].own; mask = VEC[k].mask; gc_en = VEC[k].gc; ack_en = VEC[k].ack;
      clear(3'b111);
      bus_start();
      send_frame(VEC[k].frame, ack);
      bus_stop();
      chk($sformatf("R4 ack vec%0d", k), {7'h0, ack}, {7'h0, VEC[k].e_ack});
      chk($sformatf("R3 adrs vec%0d", k), {7'h0, adrs}, {7'h0, VEC[k].e_adrs});
      chk($sformatf("R5 gcs vec%0d", k), {7'h0, gcs}, {7'h0, VEC[k].e_gcs});
      chk($sformatf("R7 R2 snoop vec%0d", k), snoop, VEC[k].frame);
      chk($sformatf("R6 buserr vec%0d", k), {7'h0, buserr}, 8'h0);
    end

    own = 7'h55; mask = 7'h05; gc_en = 1'b1; ack_en = 1'b1;
    clear(3'b111);

    // R8: rejected frame, then a byte without START is ignored
    bus_start();
    send_frame(8'h20, ack);
    chk("R8 nack", {7'h0, ack}, 8'h0);
    send_frame(8'hAA, ack);
    chk("R8 ignored ack", {7'h0, ack}, 8'h0);
    chk("R8 snoop held", snoop, 8'h20);
    chk("R8 adrs", {7'h0, adrs}, 8'h0);
    bus_stop();

    // R11: repeated START after an address phase
    bus_start();
    send_frame(8'h20, ack);
    bus_start();
    send_frame(8'hAA, ack);
    chk("R11 ack after restart", {7'h0, ack}, 8'h1);
    chk("R11 adrs", {7'h0, adrs}, 8'h1);
    chk("R11 no buserr", {7'h0, buserr}, 8'h0);
    bus_stop();

    // R9: STOP after three address bits
    clear(3'b111);
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_stop();
    chk("R9 buserr on stop", {7'h0, buserr}, 8'h1);
    chk("R9 sda released", {7'h0, sda_rel}, 8'h1);
    chk("R9 scl released", {7'h0, scl_rel}, 8'h1);
    bus_start();
    send_frame(8'hA8, ack);
    bus_stop();
    chk("R9 frame ignored ack", {7'h0, ack}, 8'h0);
    chk("R9 snoop held", snoop, 8'hAA);
    chk("R9 adrs", {7'h0, adrs}, 8'h0);

    // R10: clear BUSERR returns to idle
    clear(3'b100);
    chk("R10 buserr cleared", {7'h0, buserr}, 8'h0);
    bus_start();
    send_frame(8'hA8, ack);
    bus_stop();
    chk("R10 ack after clear", {7'h0, ack}, 8'h1);
    chk("R10 adrs after clear", {7'h0, adrs}, 8'h1);

    // R9: START after five address bits
    bus_start();
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    bus_start();
    chk("R9 buserr on start", {7'h0, buserr}, 8'h1);
    bus_stop();
    clear(3'b100);

    // R10: selective clear (adrs still 1, set gcs)
    bus_start();
    send_frame(8'h00, ack);
    bus_stop();
    chk("R5 gcs set", {7'h0, gcs}, 8'h1);
    clear(3'b010);
    chk("R10 gcs cleared", {7'h0, gcs}, 8'h0);
    chk("R10 adrs kept", {7'h0, adrs}, 8'h1);
    clear(3'b001);
    chk("R10 adrs cleared", {7'h0, adrs}, 8'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule